// File: doc/BRIEF.md
# Multi-Precision Add/Subtract Flag Unit

This block is the add/subtract arithmetic stage of a CPU with 16-bit opcodes. It handles three operation families, each at byte, word or long size. Plain operations compute `dst + src` or `dst - src`. Quick operations use a small immediate taken from the opcode in place of `src`. Extended operations also fold the stored extend flag into the sum as a carry-in or borrow-in, so that operands wider than 32 bits can be processed one long at a time, from the least significant part upward.

The result is combinational from the present inputs and the stored flags. The five condition flags are held in a register: extend (X), negative (N), zero (Z), overflow (V) and carry (C). This register loads on any clock edge where `op_valid` is high. For extended operations, Z can be cleared but never set. After a chain of parts, Z therefore reads 1 only if every part produced zero, provided the chain starts from a plain operation or with Z already set.

A small opcode recogniser also reports whether the present opcode is an extended add or subtract. It decodes the size, the memory-predecrement form bit, and the two register numbers so that a sequencer next to this block can use them.

Top module: `ext_arith_unit`

## Requirements
- R1: When `op_sub`=0, `result` is the sum `dst_opd + src_operand (+ carry-in)` truncated to the operand width, with all bits above the width driven to 0. Operand bits above the width are ignored. The `op_size` encoding is 0=byte (8 bits), 1=word (16 bits), 2=long (32 bits), and 3 behaves as long.
- R2: When `op_sub`=1, `result` is `dst_opd - src_operand (- borrow-in)` truncated in the same way.
- R3: After a valid operation, X and C both equal the carry out of bit width-1 for an add, or the borrow for a subtract.
- R4: After a valid operation, N equals the most significant bit of the truncated result (bit 7, 15 or 31).
- R5: After a valid add, V is 1 exactly when both operands have equal signs and the result sign differs. After a valid subtract, V is 1 exactly when the operand signs differ and the result sign differs from that of `dst_opd`.
- R6: For `op_kind` 0 (plain), 1 (quick) and 3 (treated as plain), Z after a valid operation is 1 exactly when the truncated result is zero.
- R7: For `op_kind` 2 (extended), the stored X is used as carry-in or borrow-in. Z after a valid operation is the old Z ANDed with "truncated result is zero".
- R8: For `op_kind` 1 (quick), the source value is `opcode[11:9]`, with 0 meaning 8, and `src_opd` is ignored.
- R9: All flags reset to 0 on `rst_n` low. While `op_valid` is low, the flags keep their values on every clock edge.
- R10: `xd_hit` is 1 exactly when `(opcode & 0xF1F0)` equals one of 0xD100/0xD140/0xD180 (extended add) or 0x9100/0x9140/0x9180 (extended subtract). `xd_sub` marks the subtract family. The remaining outputs are fields of the opcode: `xd_size`=`opcode[7:6]`, `xd_mem`=`opcode[3]`, `xd_src_reg`=`opcode[2:0]`, `xd_dst_reg`=`opcode[11:9]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_valid | input | 1 | Flags load at this clock edge when high |
| op_kind | input | 2 | 0 plain, 1 quick, 2 extended, 3 plain |
| op_sub | input | 1 | 1 subtract, 0 add |
| op_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| opcode | input | 16 | Instruction word (quick field, recogniser input) |
| src_opd | input | 32 | Source operand |
| dst_opd | input | 32 | Destination operand |
| result | output | 32 | Truncated, zero-extended result |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| xd_hit | output | 1 | Opcode is an extended add/subtract |
| xd_sub | output | 1 | Recognised opcode is the subtract family |
| xd_size | output | 2 | Size field of the opcode |
| xd_mem | output | 1 | Predecrement-memory form selected |
| xd_src_reg | output | 3 | Source register number |
| xd_dst_reg | output | 3 | Destination register number |

## Verification
The flag register is the only state in the block, and it is visible at the ports in the cycle after it loads. A wrong stored X shows up in the very next extended operation: that operation's combinational `result` is off by one. A Z that is wrongly set or cleared stays hidden until the end of a chain, so the bench runs 64-bit chains whose low parts are zero and whose high parts are zero, as well as mixes of the two. The bench also holds `op_valid` low with new operands applied, to show that no state moves without the strobe.

// File: rtl/ext_alu_pkg.sv
package ext_alu_pkg;

    localparam int DATA_W    = 32;
    localparam int OPC_W     = 16;
    localparam int NUM_SIZES = 3;
    localparam int QF_LSB    = 9;
    localparam int QF_W      = 3;
    localparam int REG_W     = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_QUICK = 2'd1,
        KIND_EXT   = 2'd2,
        KIND_ALT   = 2'd3
    } kind_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/ext_alu_quick.sv
module ext_alu_quick #(
    parameter int FLD_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic [FLD_W-1:0]  field,
    output logic [DATA_W-1:0] qval
);
    logic [FLD_W:0] q_d;

    always_comb begin
        if (field == '0) begin
            q_d = {1'b1, {FLD_W{1'b0}}};
        end else begin
            q_d = {1'b0, field};
        end
        qval = DATA_W'(q_d);
    end
endmodule

// File: rtl/ext_alu_core.sv
module ext_alu_core
    import ext_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  logic          sub,
    input  logic          cin,
    input  logic [1:0]    size,
    output logic [DW-1:0] res,
    output logic          co,
    output logic          ovf,
    output logic          neg
);
    logic [NUM_SIZES-1:0][DW-1:0] res_w;
    logic [NUM_SIZES-1:0]         co_w;
    logic [NUM_SIZES-1:0]         v_w;
    logic [NUM_SIZES-1:0]         n_w;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
        localparam int W = 8 << g;
        logic [W:0] a_ext;
        logic [W:0] b_ext;
        logic [W:0] c_ext;
        logic [W:0] sum;
        logic       d_msb;
        logic       s_msb;
        logic       r_msb;

        assign a_ext = {1'b0, dst[W-1:0]};
        assign b_ext = {1'b0, src[W-1:0]};
        assign c_ext = {{W{1'b0}}, cin};
        assign sum   = sub ? (a_ext - b_ext - c_ext) : (a_ext + b_ext + c_ext);
        assign d_msb = dst[W-1];
        assign s_msb = src[W-1];
        assign r_msb = sum[W-1];

        assign res_w[g] = DW'(sum[W-1:0]);
        assign co_w[g]  = sum[W];
        assign n_w[g]   = r_msb;
        assign v_w[g]   = sub ? ((d_msb ^ s_msb) & (r_msb ^ d_msb))
                              : (~(d_msb ^ s_msb) & (r_msb ^ d_msb));
    end

    logic [1:0] sel;

    always_comb begin
        sel = (size == SZ_RSVD) ? 2'(SZ_LONG) : size;
        res = res_w[sel];
        co  = co_w[sel];
        ovf = v_w[sel];
        neg = n_w[sel];
    end
endmodule

// File: rtl/ext_alu_xdecode.sv
module ext_alu_xdecode
    import ext_alu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic             hit,
    output logic             is_sub,
    output logic [1:0]       size,
    output logic             mem_form,
    output logic [REG_W-1:0] src_reg,
    output logic [REG_W-1:0] dst_reg
);
    localparam logic [OPC_W-1:0] XMASK     = 16'hF1F0;
    localparam logic [OPC_W-1:0] BASE_ADD  = 16'hD100;
    localparam logic [OPC_W-1:0] BASE_SUB  = 16'h9100;
    localparam logic [OPC_W-1:0] SIZE_STEP = 16'h0040;
    localparam int NFAM = 2;

    logic [NFAM*NUM_SIZES-1:0] match;

    for (genvar f = 0; f < NFAM; f++) begin : g_fam
        for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
            localparam logic [OPC_W-1:0] PAT =
                ((f == 0) ? BASE_ADD : BASE_SUB) + OPC_W'(s) * SIZE_STEP;
            assign match[f*NUM_SIZES + s] = ((opcode & XMASK) == PAT);
        end
    end

    always_comb begin
        hit      = |match;
        is_sub   = |match[NFAM*NUM_SIZES-1:NUM_SIZES];
        size     = opcode[7:6];
        mem_form = opcode[3];
        src_reg  = opcode[2:0];
        dst_reg  = opcode[11:9];
    end
endmodule

// File: rtl/ext_arith_unit.sv
module ext_arith_unit
    import ext_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic              op_sub,
    input  logic [1:0]        op_size,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] src_opd,
    input  logic [DATA_W-1:0] dst_opd,
    output logic [DATA_W-1:0] result,
    output logic              flag_x,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              xd_hit,
    output logic              xd_sub,
    output logic [1:0]        xd_size,
    output logic              xd_mem,
    output logic [REG_W-1:0]  xd_src_reg,
    output logic [REG_W-1:0]  xd_dst_reg
);
    ccr_t              ccr_d, ccr_q;
    kind_e             kind;
    logic              is_ext;
    logic [DATA_W-1:0] qval;
    logic [DATA_W-1:0] src_eff;
    logic [DATA_W-1:0] core_res;
    logic              core_co, core_v, core_n, cin;

    ext_alu_quick #(.FLD_W(QF_W), .DATA_W(DATA_W)) u_quick (
        .field (opcode[QF_LSB +: QF_W]),
        .qval  (qval)
    );

    always_comb begin
        kind    = kind_e'(op_kind);
        is_ext  = (kind == KIND_EXT);
        src_eff = (kind == KIND_QUICK) ? qval : src_opd;
        cin     = is_ext & ccr_q.x;
    end

    ext_alu_core #(.DW(DATA_W)) u_core (
        .dst  (dst_opd),
        .src  (src_eff),
        .sub  (op_sub),
        .cin  (cin),
        .size (op_size),
        .res  (core_res),
        .co   (core_co),
        .ovf  (core_v),
        .neg  (core_n)
    );

    ext_alu_xdecode u_xdec (
        .opcode   (opcode),
        .hit      (xd_hit),
        .is_sub   (xd_sub),
        .size     (xd_size),
        .mem_form (xd_mem),
        .src_reg  (xd_src_reg),
        .dst_reg  (xd_dst_reg)
    );

    // next-state computation
    always_comb begin
        ccr_d = ccr_q;
        if (op_valid) begin
            ccr_d.x = core_co;
            ccr_d.c = core_co;
            ccr_d.n = core_n;
            ccr_d.v = core_v;
            ccr_d.z = is_ext ? (ccr_q.z & (core_res == '0)) : (core_res == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccr_q <= '0;
        end else begin
            ccr_q <= ccr_d;
        end
    end

    assign result = core_res;
    assign flag_x = ccr_q.x;
    assign flag_n = ccr_q.n;
    assign flag_z = ccr_q.z;
    assign flag_v = ccr_q.v;
    assign flag_c = ccr_q.c;

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable({flag_x, flag_n, flag_z, flag_v, flag_c}));

    assert_x_tracks_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flag_x == flag_c));

    assert_zero_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd2 && !flag_z) |=> !flag_z);

    assert_neg_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flag_n == $past(op_size == 2'd0 ? result[7] :
                                      op_size == 2'd1 ? result[15] : result[31])));

    assert_zero_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != 2'd2) |=> (flag_z == ($past(result) == '0)));

    assert_dec_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xd_hit |-> (xd_size != 2'd3));
endmodule

// File: tb/test_ext_arith_unit.sv
module test_ext_arith_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic        op_sub = 1'b0;
    logic [1:0]  op_size = '0;
    logic [15:0] opcode = '0;
    logic [31:0] src_opd = '0;
    logic [31:0] dst_opd = '0;
    logic [31:0] result;
    logic        flag_x, flag_n, flag_z, flag_v, flag_c;
    logic        xd_hit, xd_sub, xd_mem;
    logic [1:0]  xd_size;
    logic [2:0]  xd_src_reg, xd_dst_reg;

    int tests = 0;
    int fails = 0;
    logic mx = 0, mn = 0, mz = 0, mv = 0, mc = 0;
    logic [31:0] last_res;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_arith_unit i_ext_arith_unit (
        .clk, .rst_n, .op_valid, .op_kind, .op_sub, .op_size, .opcode,
        .src_opd, .dst_opd, .result, .flag_x, .flag_n, .flag_z, .flag_v,
        .flag_c, .xd_hit, .xd_sub, .xd_size, .xd_mem, .xd_src_reg, .xd_dst_reg
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] k, input logic sb, input logic [1:0] sz,
                         input logic [15:0] opc, input logic [31:0] s, input logic [31:0] d);
        int w;
        logic [63:0] mask, sv, dv, cin, full, res;
        longint sd, ss, tr, lim;
        logic carry, ez;
        @(negedge clk);
        op_kind = k; op_sub = sb; op_size = sz; opcode = opc;
        src_opd = s; dst_opd = d; op_valid = 1'b1;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask = (64'd1 << w) - 1;
        if (k == 2'd1) sv = (opc[11:9] == 3'd0) ? 64'd8 : {61'd0, opc[11:9]};
        else sv = {32'd0, s} & mask;
        dv = {32'd0, d} & mask;
        cin = (k == 2'd2) ? {63'd0, mx} : 64'd0;
        if (!sb) begin
            full = dv + sv + cin;
            carry = full[w];
        end else begin
            carry = (dv < sv + cin);
            full = dv - sv - cin;
        end
        res = full & mask;
        lim = longint'(64'd1 << (w - 1));
        sd = (dv >= 64'(lim)) ? longint'(dv) - 2*lim : longint'(dv);
        ss = (sv >= 64'(lim)) ? longint'(sv) - 2*lim : longint'(sv);
        tr = sb ? (sd - ss - longint'(cin)) : (sd + ss + longint'(cin));
        ez = (k == 2'd2) ? (mz && res == 0) : (res == 0);
        #1;
        last_res = result;
        chk((k == 2'd1) ? "R8 result" : (k == 2'd2) ? "R7 result" : sb ? "R2 result" : "R1 result",
            {32'd0, result}, res);
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        mx = carry; mc = carry; mn = res[w-1];
        mv = (tr > lim - 1) || (tr < -lim);
        mz = ez;
        chk("R3 flag_x", {63'd0, flag_x}, {63'd0, mx});
        chk("R3 flag_c", {63'd0, flag_c}, {63'd0, mc});
        chk("R4 flag_n", {63'd0, flag_n}, {63'd0, mn});
        chk("R5 flag_v", {63'd0, flag_v}, {63'd0, mv});
        chk((k == 2'd2) ? "R7 flag_z" : "R6 flag_z", {63'd0, flag_z}, {63'd0, mz});
    endtask

    function automatic logic [31:0] corner(input int w, input int i);
        logic [31:0] m;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        case (i)
            0: corner = 32'd0;
            1: corner = 32'd1;
            2: corner = (m >> 1);
            3: corner = (m >> 1) + 1;
            4: corner = m;
            default: corner = 32'h5A5A_5A5A & m;
        endcase
        corner = corner | (32'hA5A5_A5A5 & ~m);
    endfunction

    task automatic chain64(input logic sb, input logic [63:0] a, input logic [63:0] b);
        logic [64:0] exp;
        logic [63:0] got;
        do_op(2'd0, sb, 2'd2, 16'h0, b[31:0], a[31:0]);
        got[31:0] = last_res;
        do_op(2'd2, sb, 2'd2, 16'h0, b[63:32], a[63:32]);
        got[63:32] = last_res;
        exp = sb ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        chk("R7 chain result", got, exp[63:0]);
        chk("R7 chain zero", {63'd0, flag_z}, {63'd0, exp[63:0] == 64'd0});
        chk("R3 chain carry", {63'd0, flag_c}, {63'd0, exp[64]});
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        chk("R9 reset flags", {59'd0, flag_x, flag_n, flag_z, flag_v, flag_c}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // byte sweep, all op kinds
        for (int d = 0; d < 256; d += 15)
            for (int s = 0; s < 256; s += 15)
                for (int k = 0; k < 3; k++)
                    for (int sb = 0; sb < 2; sb++)
                        do_op(2'(k), 1'(sb), 2'd0, 16'(d * 512 + s), 32'hCC00_0000 | 32'(s),
                              32'h3300_0000 | 32'(d));

        // overflow / carry boundaries at every size, incl. reserved size code
        for (int sz = 0; sz < 4; sz++) begin
            int w;
            w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int k = 0; k < 4; k += 2)
                        for (int sb = 0; sb < 2; sb++)
                            do_op(2'(k), 1'(sb), 2'(sz), 16'h0, corner(w, j), corner(w, i));
        end

        // quick immediate field, every value, junk in src
        for (int f = 0; f < 8; f++) begin
            do_op(2'd1, 1'b0, 2'd1, 16'(f << 9), 32'hFFFF_FFFF, 32'h0000_FFF9);
            do_op(2'd1, 1'b1, 2'd2, 16'(f << 9), 32'hFFFF_FFFF, 32'h0000_0005);
        end

        // kind code 3 behaves as plain (no carry-in even with X set)
        do_op(2'd0, 1'b0, 2'd0, 16'h0, 32'hFF, 32'h01);
        do_op(2'd3, 1'b0, 2'd0, 16'h0, 32'h10, 32'h20);

        // 64-bit chained add/subtract
        chain64(1'b0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001);
        chain64(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
        chain64(1'b0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0000);
        chain64(1'b0, 64'h7FFF_FFFF_8000_0000, 64'h0000_0000_8000_0000);
        chain64(1'b1, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001);
        chain64(1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
        chain64(1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001);

        // hold: strobe low, operands change, flags must not move
        for (int h = 0; h < 4; h++) begin
            @(negedge clk);
            op_kind = 2'(h); op_sub = h[0]; op_size = 2'(h);
            src_opd = 32'hFFFF_FFFF; dst_opd = 32'(h);
            @(posedge clk);
            #1;
            chk("R9 hold", {59'd0, flag_x, flag_n, flag_z, flag_v, flag_c},
                {59'd0, mx, mn, mz, mv, mc});
        end

        // opcode recogniser, all opcodes
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] o;
            logic eh, es;
            o = 16'(i);
            opcode = o;
            eh = ((o[15:12] == 4'hD) || (o[15:12] == 4'h9)) && o[8] &&
                 (o[7:6] != 2'd3) && (o[5:4] == 2'd0);
            es = eh && (o[15:12] == 4'h9);
            #1;
            chk("R10 decode", {52'd0, xd_hit, xd_sub, xd_size, xd_mem, xd_src_reg, xd_dst_reg},
                {52'd0, eh, es, o[7:6], o[3], o[2:0], o[11:9]});
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule